// File: doc/BRIEF.md
# PHY Energy-Detect Sleep Controller

This block decides when an Ethernet PHY port may drop into its low-power sleep state, when it wakes, and when it gives up on a wake-up that never produced a link. Sleep is allowed only while the effective sleep enable is high. That enable comes from a strap pin, or from a management-register value when the override is set, and it is always forced off in fiber mode. Once sleep is allowed, the controller counts timebase ticks during which the line shows no energy and no link. When the selected timeout expires, it puts the port to sleep.

Line energy seen while asleep opens a link-check window of the same length. A link-up during that window returns the port to normal operation. If the window closes with no link, the port goes back to sleep. A software power-down bit turns the port off no matter what the sleep state is. The management interface stays usable in every state once reset has ended. Timeouts are counted in centisecond units of a parameterised number of ticks, so a bench can use scaled-down counts.

Top module: `phy_sleep_ctrl`

## Requirements
- R1: While reset is low and on the first cycle after it, the block is awake: `asleep_o` and `link_chk_o` are 0. `mgmt_ok_o` is 0 while reset is low.
- R2: The effective enable is `ovr_val_i` when `ovr_en_i` is 1, and `sleep_pin_i` otherwise.
- R3: When `fiber_i` is 1, the block never sleeps, and it leaves sleep or link check on the next clock.
- R4: When enabled and awake, the block sleeps on the N-th tick in a row with `energy_i` and `link_up_i` both low. N is TICKS_PER_CS times 100, 200, 250 or 304 for `tmo_sel_i` equal to 0, 1, 2 or 3.
- R5: A clock edge with `energy_i` or `link_up_i` high while awake restarts the idle count. After a link is lost, a full N ticks are needed again.
- R6: `energy_i` high while asleep moves the block to link check on the next clock, with `asleep_o` 0 and `link_chk_o` 1.
- R7: `link_up_i` during link check returns the block to the awake state on the next clock. With no link for N ticks, the block goes back to sleep.
- R8: Dropping the effective enable in sleep or link check returns the block to the awake state on the next clock.
- R9: `port_pd_o` is 1 when `sw_pd_i` is 1 or the block is asleep, and 0 otherwise.
- R10: After reset, `mgmt_ok_o` is 1 in every state, including sleep and software power-down.
- R11: Only clock edges with `tick_i` high advance the idle and link-check counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_pin_i | input | 1 | Sleep enable strap pin |
| ovr_en_i | input | 1 | Register override of the pin is active |
| ovr_val_i | input | 1 | Register override value |
| tmo_sel_i | input | 2 | Timeout select: 0=1.0 s, 1=2.0 s, 2=2.5 s, 3=3.04 s |
| sw_pd_i | input | 1 | Software power-down |
| fiber_i | input | 1 | Port runs in fiber mode |
| energy_i | input | 1 | Line energy detected |
| link_up_i | input | 1 | Link established |
| tick_i | input | 1 | Timebase tick |
| port_pd_o | output | 1 | Power down the network port |
| asleep_o | output | 1 | Block is in sleep |
| link_chk_o | output | 1 | Link-check window open |
| mgmt_ok_o | output | 1 | Management access allowed |

## Verification
A vector table runs the idle timeout for every timeout select and for several enable sources: pin only, override on, override off, fiber, and pin low. This checks both the exact expiry cycle and whether sleep is allowed at all. Directed tests put a single energy pulse at the last idle tick, to tell a restarting counter from a pausing one. They also check link-check expiry against link success, and drop the enable separately in sleep and in link check. A long stretch with no tick shows that the count advances on ticks and not on clock cycles.

// File: rtl/phy_sleep_pkg.sv
// Package: state encoding and timeout unit table shared by the sleep controller.
package phy_sleep_pkg;

    typedef enum logic [1:0] {
        ST_AWAKE = 2'd0,
        ST_SLEEP = 2'd1,
        ST_LCHK  = 2'd2
    } slp_state_e;

    localparam int unsigned TMO_UNITS_MAX = 304;

    // Timeout length in centisecond units for each select code.
    function automatic int unsigned tmo_units(input logic [1:0] sel);
        case (sel)
            2'd0:    return 100;
            2'd1:    return 200;
            2'd2:    return 250;
            default: return TMO_UNITS_MAX;
        endcase
    endfunction

endpackage

// File: rtl/slp_en_resolve.sv
// Module: works out the effective sleep enable.
// Assumes all inputs are already synchronous to the block clock.
module slp_en_resolve (
    input  logic sleep_pin_i,
    input  logic ovr_en_i,
    input  logic ovr_val_i,
    input  logic fiber_i,
    output logic en_o
);
    // Choose pin or override, then block the result in fiber mode.
    always_comb begin
        en_o = (ovr_en_i ? ovr_val_i : sleep_pin_i) && !fiber_i;
    end
endmodule

// File: rtl/slp_limit_sel.sv
// Module: turns the 2-bit timeout select into a tick limit.
// Assumes TICKS_PER_CS * 304 fits in CW bits.
module slp_limit_sel #(
    parameter int unsigned TICKS_PER_CS = 10,
    parameter int unsigned CW           = 12
) (
    input  logic [1:0]    sel_i,
    output logic [CW-1:0] lim_o
);
    import phy_sleep_pkg::*;

    logic [CW-1:0] tbl [4];

    for (genvar k = 0; k < 4; k++) begin : g_tbl
        assign tbl[k] = CW'(tmo_units(2'(k)) * TICKS_PER_CS);
    end

    // Look up the limit for the current select.
    always_comb begin
        lim_o = tbl[sel_i];
    end
endmodule

// File: rtl/slp_fsm.sv
// Module: awake / sleep / link-check state machine with a shared tick counter.
// Assumes lim_i is at least 1 and never larger than 2**CW - 1.
module slp_fsm #(
    parameter int unsigned CW = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en_i,
    input  logic                      energy_i,
    input  logic                      link_up_i,
    input  logic                      tick_i,
    input  logic [CW-1:0]             lim_i,
    output phy_sleep_pkg::slp_state_e state_o
);
    import phy_sleep_pkg::*;

    slp_state_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] cnt_inc;
    logic          hit;

    // Next count value and expiry flag for the current tick.
    always_comb begin
        cnt_inc = cnt_q + 1'b1;
        hit     = tick_i && (cnt_inc >= lim_i);
    end

    // Next-state and counter logic.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        case (st_q)
            ST_AWAKE: begin
                if (!en_i || energy_i || link_up_i) begin
                    cnt_d = '0;
                end else if (hit) begin
                    st_d  = ST_SLEEP;
                    cnt_d = '0;
                end else if (tick_i) begin
                    cnt_d = cnt_inc;
                end
            end
            ST_SLEEP: begin
                cnt_d = '0;
                if (!en_i) begin
                    st_d = ST_AWAKE;
                end else if (energy_i) begin
                    st_d = ST_LCHK;
                end
            end
            ST_LCHK: begin
                if (!en_i || link_up_i) begin
                    st_d  = ST_AWAKE;
                    cnt_d = '0;
                end else if (hit) begin
                    st_d  = ST_SLEEP;
                    cnt_d = '0;
                end else if (tick_i) begin
                    cnt_d = cnt_inc;
                end
            end
            default: begin
                st_d  = ST_AWAKE;
                cnt_d = '0;
            end
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_AWAKE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign state_o = st_q;
endmodule

// File: rtl/phy_sleep_ctrl.sv
// Module: top of the PHY energy-detect sleep controller.
// Assumes tick_i is a one-cycle pulse from a free-running timebase, and
// energy_i / link_up_i come from synchronised analog and link logic.
module phy_sleep_ctrl #(
    parameter int unsigned TICKS_PER_CS = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_pin_i,
    input  logic       ovr_en_i,
    input  logic       ovr_val_i,
    input  logic [1:0] tmo_sel_i,
    input  logic       sw_pd_i,
    input  logic       fiber_i,
    input  logic       energy_i,
    input  logic       link_up_i,
    input  logic       tick_i,
    output logic       port_pd_o,
    output logic       asleep_o,
    output logic       link_chk_o,
    output logic       mgmt_ok_o
);
    import phy_sleep_pkg::*;

    localparam int unsigned MAX_LIM = TMO_UNITS_MAX * TICKS_PER_CS;
    localparam int unsigned CW      = $clog2(MAX_LIM + 1);

    logic          en;
    logic [CW-1:0] lim;
    slp_state_e    state;

    slp_en_resolve u_en (
        .sleep_pin_i (sleep_pin_i),
        .ovr_en_i    (ovr_en_i),
        .ovr_val_i   (ovr_val_i),
        .fiber_i     (fiber_i),
        .en_o        (en)
    );

    slp_limit_sel #(.TICKS_PER_CS(TICKS_PER_CS), .CW(CW)) u_lim (
        .sel_i (tmo_sel_i),
        .lim_o (lim)
    );

    slp_fsm #(.CW(CW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en),
        .energy_i  (energy_i),
        .link_up_i (link_up_i),
        .tick_i    (tick_i),
        .lim_i     (lim),
        .state_o   (state)
    );

    // Management access opens once reset has been released.
    always_ff @(posedge clk) begin
        if (!rst_n) mgmt_ok_o <= 1'b0;
        else        mgmt_ok_o <= 1'b1;
    end

    // Decode the state into the output flags.
    always_comb begin
        asleep_o   = (state == ST_SLEEP);
        link_chk_o = (state == ST_LCHK);
        port_pd_o  = sw_pd_i || asleep_o;
    end
endmodule

// File: rtl/phy_sleep_ctrl_chk.sv
// Checker: temporal properties of the sleep controller, bound to the top.
module phy_sleep_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sleep_pin_i,
    input logic       ovr_en_i,
    input logic       ovr_val_i,
    input logic       sw_pd_i,
    input logic       fiber_i,
    input logic       energy_i,
    input logic       link_up_i,
    input logic       port_pd_o,
    input logic       asleep_o,
    input logic       link_chk_o,
    input logic       mgmt_ok_o
);
    logic en_c;
    // Effective enable as seen from the ports.
    always_comb en_c = (ovr_en_i ? ovr_val_i : sleep_pin_i) && !fiber_i;

    AST_WAKE_TO_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        asleep_o && en_c && energy_i |=> link_chk_o && !asleep_o); // R6
    AST_DISABLE_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        !en_c |=> !asleep_o && !link_chk_o); // R8
    AST_LINK_EXITS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        link_chk_o && en_c && link_up_i |=> !link_chk_o && !asleep_o); // R7
    AST_QUIET_BEFORE_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep_o) && !$past(link_chk_o) |-> $past(!energy_i && !link_up_i && en_c)); // R4
    AST_SLEEP_POWERS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        asleep_o |-> port_pd_o); // R9
    AST_MGMT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        asleep_o || link_chk_o || sw_pd_i |-> mgmt_ok_o); // R10
endmodule

bind phy_sleep_ctrl phy_sleep_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_pin_i (sleep_pin_i),
    .ovr_en_i    (ovr_en_i),
    .ovr_val_i   (ovr_val_i),
    .sw_pd_i     (sw_pd_i),
    .fiber_i     (fiber_i),
    .energy_i    (energy_i),
    .link_up_i   (link_up_i),
    .port_pd_o   (port_pd_o),
    .asleep_o    (asleep_o),
    .link_chk_o  (link_chk_o),
    .mgmt_ok_o   (mgmt_ok_o)
);

// File: tb/sim_phy_sleep_ctrl.sv
`timescale 1ns/1ps
// Bench: vector table over enable sources and timeouts, then directed tests.
module sim_phy_sleep_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_pin = 1'b0, ovr_en = 1'b0, ovr_val = 1'b0, sw_pd = 1'b0;
    logic fiber = 1'b0, energy = 1'b1, link_up = 1'b0, tick = 1'b1;
    logic [1:0] tmo_sel = 2'd0;
    logic port_pd, asleep, link_chk, mgmt_ok;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // 50 MHz clock.
    always #10 clk = ~clk;

    phy_sleep_ctrl #(.TICKS_PER_CS(1)) u0 (
        .clk(clk), .rst_n(rst_n), .sleep_pin_i(sleep_pin), .ovr_en_i(ovr_en),
        .ovr_val_i(ovr_val), .tmo_sel_i(tmo_sel), .sw_pd_i(sw_pd), .fiber_i(fiber),
        .energy_i(energy), .link_up_i(link_up), .tick_i(tick), .port_pd_o(port_pd),
        .asleep_o(asleep), .link_chk_o(link_chk), .mgmt_ok_o(mgmt_ok)
    );

    // {ovr_en, ovr_val, pin, fiber, sel[1:0], expect_sleep}
    localparam logic [6:0] VEC [8] = '{
        7'b0010001, 7'b0010011, 7'b0010101, 7'b0010111,
        7'b1100001, 7'b1010110, 7'b0011000, 7'b0000000
    };

    function automatic int lim_of(input logic [1:0] s);
        case (s)
            2'd0: return 100;
            2'd1: return 200;
            2'd2: return 250;
            default: return 304;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; energy = 1'b1; link_up = 1'b0; tick = 1'b1; sw_pd = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with software power-down visible during reset.
        sw_pd = 1'b1; sleep_pin = 1'b1;
        idle(2);
        chk("R1 asleep in reset", asleep, 0);
        chk("R1 link_chk in reset", link_chk, 0);
        chk("R1 mgmt_ok in reset", mgmt_ok, 0);
        chk("R9 port_pd follows sw_pd in reset", port_pd, 1);
        sw_pd = 1'b0;
        rst_n = 1'b1;
        idle(1);
        chk("R1 awake after reset", asleep, 0);
        chk("R10 mgmt_ok after reset", mgmt_ok, 1);

        // Table walk: R2, R3, R4 under each enable source and timeout.
        for (int i = 0; i < 8; i++) begin
            do_reset();
            {ovr_en, ovr_val, sleep_pin, fiber, tmo_sel} = VEC[i][6:1];
            energy = 1'b0;
            if (VEC[i][0]) begin
                idle(lim_of(tmo_sel) - 1);
                chk($sformatf("R4 vec%0d early", i), asleep, 0);
                idle(1);
                chk($sformatf("R4 R2 vec%0d sleep at limit", i), asleep, 1);
            end else begin
                idle(320);
                chk($sformatf("R2 R3 vec%0d stays awake", i), asleep, 0);
            end
        end

        // R5: energy on the last idle tick restarts the count.
        do_reset();
        {ovr_en, ovr_val, fiber, sleep_pin, tmo_sel} = {1'b0, 1'b0, 1'b0, 1'b1, 2'd0};
        energy = 1'b0;
        idle(99);
        chk("R5 before pulse", asleep, 0);
        energy = 1'b1; idle(1); energy = 1'b0;
        idle(99);
        chk("R5 restart not pause", asleep, 0);
        idle(1);
        chk("R5 sleep after full restart", asleep, 1);
        chk("R9 port_pd while asleep", port_pd, 1);
        chk("R10 mgmt_ok while asleep", mgmt_ok, 1);

        // R6 and R7: wake into link check, then time out back to sleep.
        energy = 1'b1; idle(1); energy = 1'b0;
        chk("R6 link check open", link_chk, 1);
        chk("R6 not asleep", asleep, 0);
        chk("R9 port_pd off in link check", port_pd, 0);
        idle(99);
        chk("R7 window still open", link_chk, 1);
        idle(1);
        chk("R7 back to sleep on expiry", asleep, 1);

        // R7 link success, then R5 loss of link restarts idle timing.
        energy = 1'b1; idle(1); energy = 1'b0;
        link_up = 1'b1; idle(1);
        chk("R7 link exits check", link_chk, 0);
        chk("R7 awake on link", asleep, 0);
        idle(150);
        chk("R5 link up holds awake", asleep, 0);
        link_up = 1'b0;
        idle(99);
        chk("R5 link loss early", asleep, 0);
        idle(1);
        chk("R5 link loss full timeout", asleep, 1);

        // R8: dropping the enable in sleep and in link check.
        ovr_en = 1'b1; ovr_val = 1'b0; idle(1);
        chk("R8 sleep exits on disable", asleep, 0);
        ovr_en = 1'b0;
        idle(100);
        chk("R8 re-sleep", asleep, 1);
        energy = 1'b1; idle(1); energy = 1'b0;
        sleep_pin = 1'b0; idle(1);
        chk("R8 link check exits on disable", link_chk, 0);
        chk("R8 awake after disable", asleep, 0);
        sleep_pin = 1'b1;

        // R3: fiber mode pulls the block out of sleep.
        idle(100);
        chk("R3 asleep before fiber", asleep, 1);
        fiber = 1'b1; idle(1);
        chk("R3 fiber wakes", asleep, 0);
        fiber = 1'b0;

        // R9 and R10: software power-down while awake.
        sw_pd = 1'b1; #1;
        chk("R9 sw_pd powers down port", port_pd, 1);
        chk("R10 mgmt_ok in sw power-down", mgmt_ok, 1);
        sw_pd = 1'b0; #1;
        chk("R9 port up when awake", port_pd, 0);

        // R11: no ticks, no progress.
        @(negedge clk);
        energy = 1'b1; idle(1);
        energy = 1'b0; tick = 1'b0;
        idle(400);
        chk("R11 no sleep without ticks", asleep, 0);
        tick = 1'b1;
        idle(99);
        chk("R11 count started from zero", asleep, 0);
        idle(1);
        chk("R11 sleep after ticks", asleep, 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule